// File: doc/BRIEF.md
# Mispredict and Miss Hotspot Tracker

This block watches the retire stream and finds the static branches that mispredict most often and the static loads that most often miss in the second-level cache. Each retiring event carries a PC, a type bit and a flag that says whether the event was bad. A table tagged by PC keeps one saturating counter per static instruction. A short ranking list of the worst offenders is kept up to date on every counter change, so the table never has to be scanned when an epoch ends.

Time is cut into epochs of a fixed number of cycles. At each epoch boundary the ranking list is copied into an output buffer, and the table and the list start again from empty. The buffer then offers one record per cycle on a valid/ready stream. For a branch, the record also carries a reconvergent PC, which the block reads through a lookup port served by an outside predictor. The block is meant to feed a slice-analysis unit that works on one candidate at a time.

Top module: `dlq_classifier`

## Requirements
- R1: A flagged event whose PC is not in the table takes the lowest-numbered free entry with count 1 and keeps the event's type. Each later flagged event with the same PC adds one to that entry's count.
- R2: An event with `evFlag` low or `evValid` low changes no count and creates no entry.
- R3: A count stops at 2^CNT_W-1 and does not wrap.
- R4: When every entry is in use, a new flagged PC replaces the entry with the smallest count, with ties going to the lowest index, and starts again at count 1.
- R5: The ranking list has TOP_N slots, and an empty slot counts as zero. If the updated table index is already listed, its slot takes the new PC, type and count. If not, it takes the lowest-numbered slot with the smallest count, and only when its new count is strictly greater than that count.
- R6: An epoch lasts EPOCH_CYCLES cycles, counted from reset release, and its boundary is the last cycle of the epoch. At the boundary the table and the ranking list are emptied. A flagged event that arrives in the boundary cycle is dropped.
- R7: At a boundary, each occupied ranking slot becomes one record. The records are offered in ascending slot order, one per handshake (`recValid` and `recReady` both high). A record held back by low `recReady` stays stable.
- R8: A record gives the PC, the type (`recIsLoad`: 1 = load, 0 = branch) and the count. `lookupPc` carries the record PC. `recRcvPc` is the value returned on `lookupRcvPc` for a branch and zero for a load.
- R9: Records still unsent at the next boundary are dropped and replaced by the new epoch's records.
- R10: After reset, no record appears before the first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evValid | input | 1 | A retire event is present |
| evPc | input | PC_W | PC of the retiring instruction |
| evIsLoad | input | 1 | 1 = load, 0 = branch |
| evFlag | input | 1 | The branch mispredicted, or the load missed in L2 |
| recValid | output | 1 | A candidate record is offered |
| recReady | input | 1 | The consumer takes the record |
| recPc | output | PC_W | PC of the candidate |
| recIsLoad | output | 1 | Type of the candidate |
| recCount | output | CNT_W | Event count of the candidate in the past epoch |
| recRcvPc | output | PC_W | Reconvergent PC for a branch, zero for a load |
| lookupPc | output | PC_W | PC sent to the reconvergence lookup |
| lookupRcvPc | input | PC_W | Reconvergent PC returned for `lookupPc` |

## Verification
The assertions check on every cycle that a stalled record stays unchanged, that no record ever has a zero count, that a load record never carries a reconvergent PC, that the boundary strobe recurs at exactly the epoch period, and that records only start to appear right after a boundary. Allocation order, saturation, replacement when the table is full, the strictly-greater rule of the ranking list, the drop of an event in the boundary cycle and the loss of unsent records can only be shown by the bench's scenarios. The bench checks these by comparing the emitted records with a reference model of the rules.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  // Strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic epochEnd;  // last cycle of the epoch: snapshot and clear
    logic pop;       // head record taken by the consumer
  } dlqStrobeT;
endpackage

// File: rtl/dlq_ctrl.sv
module dlq_ctrl
  import dlq_pkg::*;
#(
  parameter int EPOCH_CYCLES = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      drainAny,
  input  logic      recReady,
  output dlqStrobeT strobes
);
  localparam int EW = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1;
  localparam logic [EW-1:0] LAST = EW'(EPOCH_CYCLES - 1);

  logic [EW-1:0] epochCnt;
  logic          atLast;

  assign atLast = (epochCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epochCnt <= '0;
    end else if (atLast) begin
      epochCnt <= '0;
    end else begin
      epochCnt <= epochCnt + 1'b1;
    end
  end

  // The boundary overwrites the output buffer, so no pop is issued then.
  always_comb begin
    strobes.epochEnd = atLast;
    strobes.pop      = drainAny & recReady & ~atLast;
  end
endmodule

// File: rtl/dlq_datapath.sv
module dlq_datapath
  import dlq_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 128,
  parameter int TOP_N   = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dlqStrobeT        strobes,
  input  logic             evValid,
  input  logic [PC_W-1:0]  evPc,
  input  logic             evIsLoad,
  input  logic             evFlag,
  output logic             drainAny,
  output logic [PC_W-1:0]  headPc,
  output logic             headIsLoad,
  output logic [CNT_W-1:0] headCnt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SL_W  = (TOP_N > 1) ? $clog2(TOP_N) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // ---------------- counting table ----------------
  logic             tblValid [ENTRIES];
  logic             tblLoad  [ENTRIES];
  logic [PC_W-1:0]  tblPc    [ENTRIES];
  logic [CNT_W-1:0] tblCnt   [ENTRIES];

  logic             hitAny, freeAny, doUpd;
  logic [IDX_W-1:0] hitIdx, freeIdx, minIdx, updIdx;
  logic [CNT_W-1:0] minCnt, updCnt;
  logic             updLoad;

  always_comb begin
    hitAny  = 1'b0;
    hitIdx  = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    // Descending scan so the lowest matching index wins.
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tblValid[i] && tblPc[i] == evPc) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!tblValid[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    // Strict compare keeps the lowest index on ties.
    minIdx = '0;
    minCnt = tblCnt[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (tblCnt[i] < minCnt) begin
        minCnt = tblCnt[i];
        minIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    doUpd = evValid & evFlag & ~strobes.epochEnd;
    if (hitAny) begin
      updIdx  = hitIdx;
      updCnt  = (tblCnt[hitIdx] == CNT_MAX) ? CNT_MAX : tblCnt[hitIdx] + 1'b1;
      updLoad = tblLoad[hitIdx];
    end else begin
      updIdx  = freeAny ? freeIdx : minIdx;
      updCnt  = CNT_W'(1);
      updLoad = evIsLoad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tblValid[i] <= 1'b0;
        tblCnt[i]   <= '0;
      end
    end else if (strobes.epochEnd) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tblValid[i] <= 1'b0;
        tblCnt[i]   <= '0;
      end
    end else if (doUpd) begin
      tblValid[updIdx] <= 1'b1;
      tblCnt[updIdx]   <= updCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (doUpd) begin
      tblPc[updIdx]   <= evPc;
      tblLoad[updIdx] <= updLoad;
    end
  end

  // ---------------- running ranking list ----------------
  logic             slValid [TOP_N];
  logic [IDX_W-1:0] slIdx   [TOP_N];
  logic [PC_W-1:0]  slPc    [TOP_N];
  logic             slLoad  [TOP_N];
  logic [CNT_W-1:0] slCnt   [TOP_N];

  logic             slHit, slWrite;
  logic [SL_W-1:0]  slHitPos, slMinPos, slPos;
  logic [CNT_W-1:0] slMinCnt;

  always_comb begin
    slHit    = 1'b0;
    slHitPos = '0;
    for (int j = TOP_N - 1; j >= 0; j--) begin
      if (slValid[j] && slIdx[j] == updIdx) begin
        slHit    = 1'b1;
        slHitPos = SL_W'(j);
      end
    end
    slMinPos = '0;
    slMinCnt = slValid[0] ? slCnt[0] : '0;
    for (int j = 1; j < TOP_N; j++) begin
      if ((slValid[j] ? slCnt[j] : '0) < slMinCnt) begin
        slMinCnt = slValid[j] ? slCnt[j] : '0;
        slMinPos = SL_W'(j);
      end
    end
    slPos   = slHit ? slHitPos : slMinPos;
    slWrite = doUpd & (slHit | (updCnt > slMinCnt));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < TOP_N; j++) slValid[j] <= 1'b0;
    end else if (strobes.epochEnd) begin
      for (int j = 0; j < TOP_N; j++) slValid[j] <= 1'b0;
    end else if (slWrite) begin
      slValid[slPos] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (slWrite) begin
      slIdx[slPos]  <= updIdx;
      slPc[slPos]   <= evPc;
      slLoad[slPos] <= updLoad;
      slCnt[slPos]  <= updCnt;
    end
  end

  // ---------------- output buffer ----------------
  logic             drnValid [TOP_N];
  logic [PC_W-1:0]  drnPc    [TOP_N];
  logic             drnLoad  [TOP_N];
  logic [CNT_W-1:0] drnCnt   [TOP_N];
  logic [SL_W-1:0]  headPos;

  always_comb begin
    drainAny = 1'b0;
    headPos  = '0;
    for (int j = TOP_N - 1; j >= 0; j--) begin
      if (drnValid[j]) begin
        drainAny = 1'b1;
        headPos  = SL_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < TOP_N; j++) drnValid[j] <= 1'b0;
    end else if (strobes.epochEnd) begin
      for (int j = 0; j < TOP_N; j++) drnValid[j] <= slValid[j];
    end else if (strobes.pop) begin
      drnValid[headPos] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.epochEnd) begin
      for (int j = 0; j < TOP_N; j++) begin
        drnPc[j]   <= slPc[j];
        drnLoad[j] <= slLoad[j];
        drnCnt[j]  <= slCnt[j];
      end
    end
  end

  assign headPc     = drnPc[headPos];
  assign headIsLoad = drnLoad[headPos];
  assign headCnt    = drnCnt[headPos];
endmodule

// File: rtl/dlq_classifier.sv
module dlq_classifier
  import dlq_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int ENTRIES      = 128,
  parameter int TOP_N        = 8,
  parameter int CNT_W        = 16,
  parameter int EPOCH_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [PC_W-1:0]  evPc,
  input  logic             evIsLoad,
  input  logic             evFlag,
  output logic             recValid,
  input  logic             recReady,
  output logic [PC_W-1:0]  recPc,
  output logic             recIsLoad,
  output logic [CNT_W-1:0] recCount,
  output logic [PC_W-1:0]  recRcvPc,
  output logic [PC_W-1:0]  lookupPc,
  input  logic [PC_W-1:0]  lookupRcvPc
);
  dlqStrobeT        ctrlS;
  logic             drainAny;
  logic [PC_W-1:0]  headPc;
  logic             headIsLoad;
  logic [CNT_W-1:0] headCnt;

  dlq_ctrl #(.EPOCH_CYCLES(EPOCH_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .drainAny(drainAny), .recReady(recReady),
    .strobes(ctrlS)
  );

  dlq_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES), .TOP_N(TOP_N), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(ctrlS),
    .evValid(evValid), .evPc(evPc), .evIsLoad(evIsLoad), .evFlag(evFlag),
    .drainAny(drainAny), .headPc(headPc), .headIsLoad(headIsLoad), .headCnt(headCnt)
  );

  assign recValid  = drainAny;
  assign recPc     = headPc;
  assign recIsLoad = headIsLoad;
  assign recCount  = headCnt;
  assign lookupPc  = headPc;
  assign recRcvPc  = headIsLoad ? '0 : lookupRcvPc;
endmodule

// File: rtl/dlq_checker.sv
module dlq_checker #(
  parameter int PC_W         = 32,
  parameter int CNT_W        = 16,
  parameter int EPOCH_CYCLES = 500000
) (
  input logic             clk,
  input logic             rstN,
  input logic             epochEnd,
  input logic             recValid,
  input logic             recReady,
  input logic [PC_W-1:0]  recPc,
  input logic             recIsLoad,
  input logic [CNT_W-1:0] recCount,
  input logic [PC_W-1:0]  recRcvPc
);
  localparam int CW = $clog2(EPOCH_CYCLES) + 1;
  logic [CW-1:0] sinceEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sinceEnd <= '0;
    else if (epochEnd) sinceEnd <= '0;
    else               sinceEnd <= sinceEnd + 1'b1;
  end

  AST_EPOCH_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    epochEnd |-> sinceEnd == CW'(EPOCH_CYCLES - 1)); // R6

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady && !epochEnd) |=>
      (recValid && $stable(recPc) && $stable(recCount) && $stable(recIsLoad))); // R7

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> recCount != '0); // R1

  AST_LOAD_NO_RCV: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recIsLoad) |-> recRcvPc == '0); // R8

  AST_RECORDS_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recValid) |-> $past(epochEnd)); // R10
endmodule

bind dlq_classifier dlq_checker #(
  .PC_W(PC_W), .CNT_W(CNT_W), .EPOCH_CYCLES(EPOCH_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .epochEnd(ctrlS.epochEnd),
  .recValid(recValid), .recReady(recReady), .recPc(recPc),
  .recIsLoad(recIsLoad), .recCount(recCount), .recRcvPc(recRcvPc)
);

// File: tb/dlq_classifier_tb_top.sv
`timescale 1ns/1ps
module dlq_classifier_tb_top;
  localparam int PW = 32;
  localparam int NE = 8;
  localparam int NT = 4;
  localparam int CW = 4;
  localparam int EP = 300;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, evValid, evIsLoad, evFlag, recValid, recReady, recIsLoad;
  logic [PW-1:0] evPc, recPc, recRcvPc, lookupPc, lookupRcvPc;
  logic [CW-1:0] recCount;

  dlq_classifier #(.PC_W(PW), .ENTRIES(NE), .TOP_N(NT), .CNT_W(CW), .EPOCH_CYCLES(EP)) dut_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evPc(evPc), .evIsLoad(evIsLoad),
    .evFlag(evFlag), .recValid(recValid), .recReady(recReady), .recPc(recPc),
    .recIsLoad(recIsLoad), .recCount(recCount), .recRcvPc(recRcvPc),
    .lookupPc(lookupPc), .lookupRcvPc(lookupRcvPc)
  );

  // Reconvergence lookup stand-in.
  assign lookupRcvPc = lookupPc + 32'h40;

  int checks = 0;
  int fails = 0;
  int mcyc = 0;
  bit earlyRec = 0;
  bit finished = 0;

  typedef struct { logic [PW-1:0] pc; logic ld; int cnt; } recT;
  recT expQ[$];
  logic [PW-1:0] gotPc[$];
  int gotCnt[$];
  int gotEp[$];

  // Reference model state.
  bit mtV[NE]; logic [PW-1:0] mtPc[NE]; bit mtL[NE]; int mtC[NE];
  bit msV[NT]; int msIdx[NT]; logic [PW-1:0] msPc[NT]; bit msL[NT]; int msC[NT];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void modelClear();
    for (int i = 0; i < NE; i++) begin mtV[i] = 0; mtC[i] = 0; end
    for (int j = 0; j < NT; j++) msV[j] = 0;
  endfunction

  function automatic void modelUpdate(logic [PW-1:0] pc, bit ld);
    int hit = -1, idx, cnt, sh = -1, mp, mc;
    bit l;
    for (int i = 0; i < NE; i++) if (hit < 0 && mtV[i] && mtPc[i] == pc) hit = i;
    if (hit >= 0) begin
      idx = hit; cnt = (mtC[hit] >= CMAX) ? CMAX : mtC[hit] + 1; l = mtL[hit];
    end else begin
      idx = -1;
      for (int i = 0; i < NE; i++) if (idx < 0 && !mtV[i]) idx = i;
      if (idx < 0) begin
        idx = 0;
        for (int i = 1; i < NE; i++) if (mtC[i] < mtC[idx]) idx = i;
      end
      cnt = 1; l = ld;
    end
    mtV[idx] = 1; mtPc[idx] = pc; mtL[idx] = l; mtC[idx] = cnt;
    for (int j = 0; j < NT; j++) if (sh < 0 && msV[j] && msIdx[j] == idx) sh = j;
    if (sh < 0) begin
      mp = 0; mc = msV[0] ? msC[0] : 0;
      for (int j = 1; j < NT; j++) if ((msV[j] ? msC[j] : 0) < mc) begin
        mp = j; mc = msV[j] ? msC[j] : 0;
      end
      if (cnt > mc) sh = mp;
    end
    if (sh >= 0) begin
      msV[sh] = 1; msIdx[sh] = idx; msPc[sh] = pc; msL[sh] = l; msC[sh] = cnt;
    end
  endfunction

  // Model steps on each edge with the same inputs the design sees.
  always @(posedge clk) begin
    if (!rstN) begin
      mcyc = 0; modelClear(); expQ.delete();
    end else begin
      if (mcyc % EP == EP - 1) begin
        expQ.delete();
        for (int j = 0; j < NT; j++)
          if (msV[j]) expQ.push_back('{pc: msPc[j], ld: msL[j], cnt: msC[j]});
        modelClear();
      end else if (evValid && evFlag) begin
        modelUpdate(evPc, evIsLoad);
      end
      mcyc++;
    end
  end

  // Monitor: pops the scoreboard on each handshake.
  always begin
    @(negedge clk);
    #1;
    if (rstN && recValid) begin
      if (mcyc < EP) earlyRec = 1;
      if (recReady) begin
        if (expQ.size() == 0) begin
          check(0, "R7", "record with nothing expected, pc", recPc, 0);
        end else begin
          recT e;
          logic [PW-1:0] er;
          e = expQ.pop_front();
          er = e.ld ? '0 : e.pc + 32'h40;
          check(recPc == e.pc, "R7", "record order pc", recPc, e.pc);
          check(recIsLoad == e.ld && recCount == CW'(e.cnt), "R8",
                "record type*100+count", recIsLoad * 100 + recCount, e.ld * 100 + e.cnt);
          check(recRcvPc == er && lookupPc == e.pc, "R8", "reconvergent pc", recRcvPc, er);
        end
        gotPc.push_back(recPc);
        gotCnt.push_back(int'(recCount));
        gotEp.push_back(mcyc / EP);
      end
    end
  end

  function automatic int gotCount(logic [PW-1:0] pc, int ep);
    for (int k = 0; k < gotPc.size(); k++)
      if (gotPc[k] == pc && gotEp[k] == ep) return gotCnt[k];
    return -1;
  endfunction

  function automatic int nRecs(int ep);
    int n = 0;
    for (int k = 0; k < gotEp.size(); k++) if (gotEp[k] == ep) n++;
    return n;
  endfunction

  task automatic send(input logic [PW-1:0] pc, input bit ld, input bit flag);
    evValid = 1; evPc = pc; evIsLoad = ld; evFlag = flag;
    @(negedge clk);
    evValid = 0; evFlag = 0;
  endtask

  task automatic waitEdge(input int n);
    while (mcyc != n) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  localparam logic [PW-1:0] PC_A = 32'h1000, PC_D = 32'h1100, PC_E = 32'h2000;
  localparam logic [PW-1:0] PC_B = 32'h2100, PC_Q = 32'h4000, PC_G = 32'h5000;
  localparam logic [PW-1:0] PC_Z = 32'h6000;

  initial begin
    #100000;
    check(0, "R7", "watchdog expired at cycle", mcyc, 0);
    finish();
  end

  initial begin
    rstN = 0; evValid = 0; evPc = '0; evIsLoad = 0; evFlag = 0; recReady = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(recValid == 0, "R10", "recValid after reset", recValid, 0);
    @(negedge clk);

    // Epoch 1: allocation, ignored events, saturation, full-table replacement.
    for (int k = 0; k < 3; k++) send(PC_A, 0, 1);
    for (int k = 0; k < 6; k++) send(PC_D, 0, 0);
    for (int k = 0; k < 20; k++) send(PC_E, 1, 1);
    for (int k = 0; k < 5; k++) send(PC_B, 1, 1);
    for (int k = 0; k < 5; k++) send(32'h3000 + 32'(k * 4), 0, 1);
    for (int k = 0; k < 2; k++) send(PC_Q, 0, 1);

    waitEdge(EP + 1);
    recReady = 0;
    repeat (3) @(negedge clk);
    recReady = 1;

    // Epoch 2: records left pending across the next boundary.
    waitEdge(EP + 20);
    for (int k = 0; k < 2; k++) send(PC_A, 0, 1);
    send(PC_B, 1, 1);
    waitEdge(2 * EP - 10);
    recReady = 0;

    // Epoch 3: fresh counts, event in the boundary cycle.
    waitEdge(2 * EP + 5);
    for (int k = 0; k < 4; k++) send(PC_G, 0, 1);
    send(PC_A, 0, 1);
    waitEdge(3 * EP - 1);
    send(PC_Z, 0, 1);
    waitEdge(3 * EP + 5);
    recReady = 1;
    waitEdge(3 * EP + 30);

    check(gotCount(PC_A, 1) == 3, "R1", "count of A", gotCount(PC_A, 1), 3);
    check(gotCount(PC_D, 1) == -1, "R2", "unflagged D listed", gotCount(PC_D, 1), -1);
    check(gotCount(PC_E, 1) == CMAX, "R3", "saturated count of E", gotCount(PC_E, 1), CMAX);
    check(gotCount(PC_Q, 1) == 2, "R4", "count of replacing Q", gotCount(PC_Q, 1), 2);
    check(gotCount(32'h3000, 1) == -1, "R4", "evicted entry listed", gotCount(32'h3000, 1), -1);
    check(gotCount(32'h3004, 1) == -1, "R5", "equal count entered list", gotCount(32'h3004, 1), -1);
    check(gotCount(PC_B, 1) == 5, "R5", "count of B", gotCount(PC_B, 1), 5);
    check(nRecs(1) == NT, "R7", "records from first epoch", nRecs(1), NT);
    check(nRecs(2) == 0, "R9", "records taken while stalled", nRecs(2), 0);
    check(gotCount(PC_B, 3) == -1, "R9", "stale record of B after boundary", gotCount(PC_B, 3), -1);
    check(gotCount(PC_G, 3) == 4, "R9", "new record of G", gotCount(PC_G, 3), 4);
    check(gotCount(PC_A, 3) == 1, "R6", "count of A after clear", gotCount(PC_A, 3), 1);
    check(gotCount(PC_Z, 3) == -1, "R6", "boundary-cycle event listed", gotCount(PC_Z, 3), -1);
    check(expQ.size() == 0, "R7", "records never offered", expQ.size(), 0);
    check(!earlyRec, "R10", "record before first boundary", earlyRec, 0);
    finish();
  end
endmodule